// File: doc/BRIEF.md
# Line Buffer Configuration Selector

This block chooses how a display scaler's line buffer memory is split among luma, chroma and alpha planes. It picks the first configuration that can hold enough lines for the vertical filter. The caller presents one request and pulses `start`. The request holds the viewport widths for luma and chroma, the output rectangle width, a pixel depth code, an alpha flag, a 4:2:0 flag, the vertical tap counts and the ceiling of the vertical scale ratios. When `start` is taken the block captures all of these.

For every one of four candidate configurations, it works out how many whole lines of each plane fit. The memory is counted in 72-bit words. The block uses one shared serial divider for this work. It then tests each luma/chroma pair against the tap requirement and selects one configuration by fixed priority. It returns that configuration, the luma and chroma line (partition) counts for it, and an error flag when no configuration fits.

The latency is fixed. All twelve divisions always run, even when an earlier configuration already fits, so the result arrives a known number of cycles after `start`.

Top module: `lb_cfg_select`

## Requirements
- R1: The luma line size is min(`vp_w_y`, `rec_w`). The chroma line size is min(`vp_w_c`, `rec_w`). A line size of 0 is used as 1.
- R2: The depth code sets the bits per component: 0 gives 10, 1 gives 8, 2 gives 6 and 3 gives 12. Words per luma or chroma line are ceil(size*bpc/72). Alpha words per line are ceil(luma size/6).
- R3: Each plane's partition count is floor(capacity/words per line). The capacities in luma/chroma/alpha order are:
  - configuration 1: 816/816/984
  - configuration 2: 1088/1088/1312
  - configuration 3: 4448/1904/2752
  - configuration 0: 2752/2752/2752
- R4: With `alpha_en` high, the luma count is lowered to the alpha count when the alpha count is smaller. Both reported counts saturate at 64.
- R5: A plane fits when its taps are at most count-ceil+2 if its ratio ceiling exceeds 2. Otherwise it fits when its taps are at most its count. A configuration fits when both luma and chroma fit.
- R6: The selection order is configuration 1, then 2, then 3 (only when `is420` is high). Configuration 0 is the fallback.
- R7: With `force_max` high, configuration 0 is reported, with its own counts.
- R8: `err` is high only when configuration 0 is reported and configuration 0 does not fit.
- R9: `busy` rises after the edge that takes `start`. Exactly 170 edges later (12*14+2), `busy` falls and `done` is high for one cycle while the new results appear.
- R10: `start` is ignored while busy. Inputs that change after `start` is taken have no effect. The outputs hold between results.
- R11: After reset, `busy`, `done`, `err`, `cfg` and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken when idle |
| force_max | input | 1 | Report configuration 0 directly |
| is420 | input | 1 | Source is 4:2:0, enables configuration 3 |
| alpha_en | input | 1 | Alpha plane stored |
| depth | input | 2 | Pixel depth code |
| vp_w_y | input | WW | Luma viewport width |
| vp_w_c | input | WW | Chroma viewport width |
| rec_w | input | WW | Output rectangle width |
| vtaps_y | input | TW | Luma vertical taps |
| vtaps_c | input | TW | Chroma vertical taps |
| vceil_y | input | RW | Ceiling of luma vertical ratio |
| vceil_c | input | RW | Ceiling of chroma vertical ratio |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| cfg | output | 2 | Selected configuration |
| parts_y | output | 7 | Luma partition count |
| parts_c | output | 7 | Chroma partition count |
| err | output | 1 | Fallback does not fit |

## Verification
The directed requests are chosen so that each lands on a different configuration:
- Full-HD 10-bit lands on configuration 2.
- A narrow line lands on configuration 1.
- A 4:2:0 4K request lands on configuration 3.
- A ratio ceiling of 3 pushes a request to configuration 0.

Alpha limiting is isolated by a 4K request that fits with alpha off and raises `err` with it on. Zero widths and force-max separate the 64 saturation from the raw quotient. A request whose viewport is wider than the output rectangle shows which width is used. A start pulse and input changes during a busy window show that captured state is used. A batch of random requests is compared every clock against a behavioural model, which catches latency and holding errors.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;
  localparam int NCFG     = 4;
  localparam int NPLANE   = 3;
  localparam int CAP_W    = 13;
  localparam int PART_CAP = 64;
  localparam int PART_W   = $clog2(PART_CAP + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_PICK} lbsel_state_e;

  // words available to one plane (0 luma, 1 chroma, 2 alpha) in one configuration
  function automatic logic [CAP_W-1:0] cap_words(input logic [1:0] cfg, input logic [1:0] plane);
    logic [CAP_W-1:0] r;
    case (cfg)
      2'd1:    r = (plane == 2'd2) ? CAP_W'(984)  : CAP_W'(816);
      2'd2:    r = (plane == 2'd2) ? CAP_W'(1312) : CAP_W'(1088);
      2'd3:    r = (plane == 2'd0) ? CAP_W'(816 + 1088 + 3 * 848) :
                   (plane == 2'd1) ? CAP_W'(816 + 1088) : CAP_W'(984 + 1312 + 456);
      default: r = (plane == 2'd2) ? CAP_W'(984 + 1312 + 456) : CAP_W'(816 + 1088 + 848);
    endcase
    return r;
  endfunction

  function automatic logic [3:0] depth_bpc(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd10;
      2'd1:    return 4'd8;
      2'd2:    return 4'd6;
      default: return 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/lbsel_div.sv
module lbsel_div #(
  parameter int NW = 13,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          vld,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem;
  logic [NW-1:0] q;
  logic [DW-1:0] den_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   sh;
  logic          fits;

  assign sh   = {rem[DW-1:0], q[NW-1]};
  assign fits = sh >= {1'b0, den_r};
  assign quo  = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; q <= '0; den_r <= '0; cnt <= '0; run <= 1'b0; vld <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (go) begin
        rem <= '0; q <= num; den_r <= den; cnt <= CW'(NW); run <= 1'b1;
      end else if (run) begin
        rem <= fits ? (sh - {1'b0, den_r}) : sh;
        q   <= {q[NW-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          vld <= 1'b1;
        end
      end
    end
  end

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst) go |-> den != '0); // R1
  AST_DIV_REMAINDER: assert property (@(posedge clk) disable iff (rst) vld |-> rem < {1'b0, den_r}); // R3
endmodule

// File: rtl/lbsel_fit.sv
module lbsel_fit #(
  parameter int TW = 4,
  parameter int RW = 4,
  parameter int PW = 7
) (
  input  logic [TW-1:0] taps,
  input  logic [RW-1:0] ceilv,
  input  logic [PW-1:0] parts,
  output logic          ok
);
  localparam int SW = TW + RW + PW;
  logic [SW-1:0] need, have;

  always_comb begin
    if (ceilv > RW'(2)) begin
      need = SW'(taps) + SW'(ceilv);
      have = SW'(parts) + SW'(2);
    end else begin
      need = SW'(taps);
      have = SW'(parts);
    end
    ok = need <= have;
  end
endmodule

// File: rtl/lb_cfg_select.sv
module lb_cfg_select
  import lbsel_pkg::*;
#(
  parameter int WW = 14,
  parameter int TW = 4,
  parameter int RW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              force_max,
  input  logic              is420,
  input  logic              alpha_en,
  input  logic [1:0]        depth,
  input  logic [WW-1:0]     vp_w_y,
  input  logic [WW-1:0]     vp_w_c,
  input  logic [WW-1:0]     rec_w,
  input  logic [TW-1:0]     vtaps_y,
  input  logic [TW-1:0]     vtaps_c,
  input  logic [RW-1:0]     vceil_y,
  input  logic [RW-1:0]     vceil_c,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cfg,
  output logic [PART_W-1:0] parts_y,
  output logic [PART_W-1:0] parts_c,
  output logic              err
);
  localparam int PRODW = WW + 4;

  lbsel_state_e  state;
  logic [1:0]    cfg_i, pl_i, nx_cfg, nx_pl;
  logic          go, last;
  logic [WW-1:0] wy_r, wc_r, wa_r;
  logic          alpha_r, is420_r, force_r;
  logic [TW-1:0] taps_y_r, taps_c_r;
  logic [RW-1:0] ceil_y_r, ceil_c_r;
  logic [CAP_W-1:0] qtab [NCFG][NPLANE];

  // line sizes and words per line from the live inputs, captured on start
  logic [WW-1:0] line_y, line_c, wy, wc, wa;
  logic [3:0]    bpc;
  always_comb begin
    line_y = (vp_w_y < rec_w) ? vp_w_y : rec_w;
    line_c = (vp_w_c < rec_w) ? vp_w_c : rec_w;
    if (line_y == '0) line_y = WW'(1);
    if (line_c == '0) line_c = WW'(1);
    bpc = depth_bpc(depth);
    wy  = WW'((PRODW'(line_y) * PRODW'(bpc) + PRODW'(71)) / PRODW'(72));
    wc  = WW'((PRODW'(line_c) * PRODW'(bpc) + PRODW'(71)) / PRODW'(72));
    wa  = WW'((PRODW'(line_y) + PRODW'(5)) / PRODW'(6));
  end

  // serial division job sequencing
  logic             dv_vld;
  logic [CAP_W-1:0] dv_q;
  logic [WW-1:0]    dv_den;

  assign last = (cfg_i == 2'd3) && (pl_i == 2'd2);
  assign busy = (state != ST_IDLE);

  always_comb begin
    go = 1'b0; nx_cfg = cfg_i; nx_pl = pl_i;
    if (state == ST_LOAD) begin
      go = 1'b1; nx_cfg = 2'd0; nx_pl = 2'd0;
    end else if (state == ST_WAIT && dv_vld && !last) begin
      go = 1'b1;
      if (pl_i == 2'd2) begin
        nx_pl = 2'd0; nx_cfg = cfg_i + 2'd1;
      end else begin
        nx_pl = pl_i + 2'd1;
      end
    end
    dv_den = (nx_pl == 2'd2) ? wa_r : (nx_pl == 2'd1) ? wc_r : wy_r;
  end

  lbsel_div #(.NW(CAP_W), .DW(WW)) u_div (
    .clk(clk), .rst(rst), .go(go), .num(cap_words(nx_cfg, nx_pl)), .den(dv_den),
    .vld(dv_vld), .quo(dv_q)
  );

  // per-configuration counts and fit test
  logic [PART_W-1:0] py_c [NCFG];
  logic [PART_W-1:0] pc_c [NCFG];
  logic [NCFG-1:0]   ok;

  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    logic [CAP_W-1:0] y_lim;
    logic oky, okc;
    assign y_lim   = (alpha_r && qtab[c][2] < qtab[c][0]) ? qtab[c][2] : qtab[c][0];
    assign py_c[c] = (y_lim > CAP_W'(PART_CAP)) ? PART_W'(PART_CAP) : PART_W'(y_lim);
    assign pc_c[c] = (qtab[c][1] > CAP_W'(PART_CAP)) ? PART_W'(PART_CAP) : PART_W'(qtab[c][1]);
    lbsel_fit #(.TW(TW), .RW(RW), .PW(PART_W)) u_fy (
      .taps(taps_y_r), .ceilv(ceil_y_r), .parts(py_c[c]), .ok(oky));
    lbsel_fit #(.TW(TW), .RW(RW), .PW(PART_W)) u_fc (
      .taps(taps_c_r), .ceilv(ceil_c_r), .parts(pc_c[c]), .ok(okc));
    assign ok[c] = oky & okc;
  end

  logic [1:0] sel;
  always_comb begin
    if (force_r)               sel = 2'd0;
    else if (ok[1])            sel = 2'd1;
    else if (ok[2])            sel = 2'd2;
    else if (is420_r && ok[3]) sel = 2'd3;
    else                       sel = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cfg_i <= '0; pl_i <= '0; done <= 1'b0;
      cfg <= '0; parts_y <= '0; parts_c <= '0; err <= 1'b0;
      wy_r <= '0; wc_r <= '0; wa_r <= '0; alpha_r <= 1'b0; is420_r <= 1'b0; force_r <= 1'b0;
      taps_y_r <= '0; taps_c_r <= '0; ceil_y_r <= '0; ceil_c_r <= '0;
      for (int c = 0; c < NCFG; c++)
        for (int p = 0; p < NPLANE; p++) qtab[c][p] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          wy_r <= wy; wc_r <= wc; wa_r <= wa;
          alpha_r <= alpha_en; is420_r <= is420; force_r <= force_max;
          taps_y_r <= vtaps_y; taps_c_r <= vtaps_c; ceil_y_r <= vceil_y; ceil_c_r <= vceil_c;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          cfg_i <= nx_cfg; pl_i <= nx_pl; state <= ST_WAIT;
        end
        ST_WAIT: if (dv_vld) begin
          qtab[cfg_i][pl_i] <= dv_q;
          if (last) state <= ST_PICK;
          else begin
            cfg_i <= nx_cfg; pl_i <= nx_pl;
          end
        end
        default: begin
          cfg <= sel; parts_y <= py_c[sel]; parts_c <= pc_c[sel];
          err <= (sel == 2'd0) && !ok[0];
          done <= 1'b1; state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_PARTS_MAX: assert property (@(posedge clk) disable iff (rst)
    parts_y <= PART_W'(PART_CAP) && parts_c <= PART_W'(PART_CAP)); // R4
  AST_CFG3_ONLY_420: assert property (@(posedge clk) disable iff (rst)
    done && cfg == 2'd3 |-> is420_r && !force_r); // R6
  AST_FORCE_CFG0: assert property (@(posedge clk) disable iff (rst)
    done && force_r |-> cfg == 2'd0); // R7
  AST_ERR_ONLY_CFG0: assert property (@(posedge clk) disable iff (rst)
    done && err |-> cfg == 2'd0); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cfg) && $stable(parts_y) && $stable(parts_c) && $stable(err)); // R10
endmodule

// File: tb/sim_lb_cfg_select.sv
`timescale 1ns/1ps
module sim_lb_cfg_select;
  localparam int WW = 14, TW = 4, RW = 4;
  localparam int LAT = 12 * (13 + 1) + 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic force_max = 1'b0, is420 = 1'b0, alpha_en = 1'b0;
  logic [1:0] depth = '0;
  logic [WW-1:0] vp_w_y = '0, vp_w_c = '0, rec_w = '0;
  logic [TW-1:0] vtaps_y = '0, vtaps_c = '0;
  logic [RW-1:0] vceil_y = '0, vceil_c = '0;
  logic busy, done, err;
  logic [1:0] cfg;
  logic [6:0] parts_y, parts_c;

  always #2.5 clk = ~clk;

  lb_cfg_select #(.WW(WW), .TW(TW), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .start(start), .force_max(force_max), .is420(is420),
    .alpha_en(alpha_en), .depth(depth), .vp_w_y(vp_w_y), .vp_w_c(vp_w_c), .rec_w(rec_w),
    .vtaps_y(vtaps_y), .vtaps_c(vtaps_c), .vceil_y(vceil_y), .vceil_c(vceil_c),
    .busy(busy), .done(done), .cfg(cfg), .parts_y(parts_y), .parts_c(parts_c), .err(err));

  int checks = 0, fails = 0;
  bit wd_hit = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit fits(input int t, input int cv, input int p);
    if (cv > 2) return t <= p - cv + 2;
    return t <= p;
  endfunction

  function automatic void ref_pick(input int vy, input int vc, input int rw, input int dc,
      input int al, input int f420, input int fmax, input int ty, input int tc,
      input int cy, input int cc, output int ocfg, output int opy, output int opc, output int oerr);
    int ly, lc, bpc, wy, wc, wa, a;
    int capy[4], capc[4], capa[4], py[4], pc[4];
    bit okk[4];
    capy = '{2752, 816, 1088, 4448};
    capc = '{2752, 816, 1088, 1904};
    capa = '{2752, 984, 1312, 2752};
    ly = (vy < rw) ? vy : rw; if (ly == 0) ly = 1;
    lc = (vc < rw) ? vc : rw; if (lc == 0) lc = 1;
    bpc = (dc == 0) ? 10 : (dc == 1) ? 8 : (dc == 2) ? 6 : 12;
    wy = (ly * bpc + 71) / 72;
    wc = (lc * bpc + 71) / 72;
    wa = (ly + 5) / 6;
    for (int c = 0; c < 4; c++) begin
      py[c] = capy[c] / wy;
      a = capa[c] / wa;
      if (al != 0 && a < py[c]) py[c] = a;
      if (py[c] > 64) py[c] = 64;
      pc[c] = capc[c] / wc;
      if (pc[c] > 64) pc[c] = 64;
      okk[c] = fits(ty, cy, py[c]) && fits(tc, cc, pc[c]);
    end
    if (fmax != 0) ocfg = 0;
    else if (okk[1]) ocfg = 1;
    else if (okk[2]) ocfg = 2;
    else if (f420 != 0 && okk[3]) ocfg = 3;
    else ocfg = 0;
    opy = py[ocfg]; opc = pc[ocfg];
    oerr = (ocfg == 0 && !okk[0]) ? 1 : 0;
  endfunction

  // behavioural model, advanced on every rising edge
  int ebusy = 0, edone = 0, ecnt = 0, ecfg = 0, epy = 0, epc = 0, eerr = 0;
  int qcfg, qpy, qpc, qerr;
  always @(posedge clk) begin
    if (rst) begin
      ebusy = 0; edone = 0; ecnt = 0; ecfg = 0; epy = 0; epc = 0; eerr = 0;
    end else begin
      edone = 0;
      if (ebusy != 0) begin
        ecnt = ecnt - 1;
        if (ecnt == 0) begin
          ebusy = 0; edone = 1; ecfg = qcfg; epy = qpy; epc = qpc; eerr = qerr;
        end
      end else if (start) begin
        ebusy = 1; ecnt = LAT;
        ref_pick(int'(vp_w_y), int'(vp_w_c), int'(rec_w), int'(depth), int'(alpha_en),
                 int'(is420), int'(force_max), int'(vtaps_y), int'(vtaps_c),
                 int'(vceil_y), int'(vceil_c), qcfg, qpy, qpc, qerr);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !wd_hit) begin
      chk("R9 busy", int'(busy), ebusy);
      chk("R9 done", int'(done), edone);
      chk("R6 cfg", int'(cfg), ecfg);
      chk("R4 parts_y", int'(parts_y), epy);
      chk("R4 parts_c", int'(parts_c), epc);
      chk("R8 err", int'(err), eerr);
    end
  end

  task automatic setup(input int vy, input int vc, input int rw, input int dc, input int al,
      input int f420, input int fmax, input int ty, input int tc, input int cy, input int cc);
    vp_w_y = WW'(vy); vp_w_c = WW'(vc); rec_w = WW'(rw); depth = 2'(dc);
    alpha_en = al[0]; is420 = f420[0]; force_max = fmax[0];
    vtaps_y = TW'(ty); vtaps_c = TW'(tc); vceil_y = RW'(cy); vceil_c = RW'(cc);
  endtask

  task automatic run_wait();
    int k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < LAT + 20) begin
      @(negedge clk);
      k++;
    end
    chk("R9 latency", k, LAT);
  endtask

  task automatic expect_out(input string tag, input int c, input int py, input int pc, input int e);
    chk({tag, " cfg"}, int'(cfg), c);
    chk({tag, " parts_y"}, int'(parts_y), py);
    chk({tag, " parts_c"}, int'(parts_c), pc);
    chk({tag, " err"}, int'(err), e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    expect_out("R11", 0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3: 1920 at 10 bpc -> 267 words, cfg1 gives 3, cfg2 gives 4
    setup(1920, 1920, 1920, 0, 0, 0, 0, 4, 4, 1, 1); run_wait();
    expect_out("R3", 2, 4, 4, 0);
    // R6: narrow line fits configuration 1
    setup(256, 256, 256, 0, 0, 0, 0, 4, 4, 1, 1); run_wait();
    expect_out("R6", 1, 22, 22, 0);
    // R1: output rectangle narrower than viewport
    setup(4000, 4000, 256, 0, 0, 0, 0, 4, 4, 1, 1); run_wait();
    expect_out("R1", 1, 22, 22, 0);
    // R1 zero widths treated as one, R4 saturation at 64
    setup(0, 0, 0, 0, 0, 0, 0, 4, 4, 1, 1); run_wait();
    chk("R1 zero cfg", int'(cfg), 1);
    chk("R4 zero parts_y", int'(parts_y), 64);
    chk("R4 zero parts_c", int'(parts_c), 64);
    // R2: 12 bpc depth code 3, 1920 -> 320 words
    setup(1920, 1920, 1920, 3, 0, 0, 0, 2, 2, 1, 1); run_wait();
    expect_out("R2", 1, 2, 2, 0);
    // R5: ratio ceiling 3 needs five lines for four taps
    setup(1920, 1920, 1920, 0, 0, 0, 0, 4, 4, 3, 3); run_wait();
    expect_out("R5", 0, 10, 10, 0);
    // R4: 4K 8 bpc without alpha fits configuration 0
    setup(3840, 3840, 3840, 1, 0, 0, 0, 5, 5, 1, 1); run_wait();
    expect_out("R4 no alpha", 0, 6, 6, 0);
    // R8: alpha limits luma to 4, fallback fails
    setup(3840, 3840, 3840, 1, 1, 0, 0, 5, 5, 1, 1); run_wait();
    expect_out("R8", 0, 4, 6, 1);
    // R6: 4:2:0 reaches configuration 3
    setup(3840, 1920, 3840, 1, 0, 1, 0, 5, 5, 1, 1); run_wait();
    expect_out("R6 420", 3, 10, 8, 0);
    // R7: force maximum
    setup(256, 256, 256, 0, 0, 0, 1, 4, 4, 1, 1); run_wait();
    expect_out("R7", 0, 64, 64, 0);
    // R10: start and input changes while busy are ignored
    setup(256, 256, 256, 0, 0, 0, 0, 4, 4, 1, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    setup(3840, 3840, 3840, 1, 1, 0, 1, 8, 8, 4, 4);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    expect_out("R10", 1, 22, 22, 0);
    @(negedge clk);
    expect_out("R10 hold", 1, 22, 22, 0);
    // random requests compared against the model every clock
    for (int i = 0; i < 30; i++) begin
      setup($urandom_range(0, 8000), $urandom_range(0, 8000), $urandom_range(0, 8000),
            $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
            ($urandom_range(0, 7) == 0) ? 1 : 0, $urandom_range(1, 8), $urandom_range(1, 8),
            $urandom_range(1, 4), $urandom_range(1, 4));
      run_wait();
      expect_out("R6 random", qcfg, qpy, qpc, qerr);
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule